// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory with Self-Timed Page Programming

This block is a synchronous, device-side model of a byte-wide nonvolatile memory. A host drives active-low chip select (`ce_n`), read strobe (`oe_n`) and write strobe (`we_n`), an address and a data byte. The system clock samples all three strobes. Each write strobe cycle loads one byte into a page buffer. The page is the upper address field and the offset is the low `OFF_W` bits.

The page stays open for as long as each new load starts within a load window of `WINDOW_CYC` clocks. When a window passes with no new load, the block enters a self-timed programming phase of `PROG_CYC` clocks. It then copies every buffered byte into the internal array, one offset per clock.

While the block is busy, any read returns a polling status byte instead of array data. A separate debug read port exposes the array to the testbench. The default configuration is a 2K x 8 array with 64-byte pages. Setting `ADDR_W` to 13 gives 8K x 8.

Top module: `eeprom_page_engine`

## Requirements
- R1: A write cycle is active while `ce_n`=0, `we_n`=0 and `oe_n`=1. The address is captured in the clock where that condition first becomes true, so it comes from the later of the two falling strobes. The data is the `din` value of the last clock before the condition ends, so it comes from the earlier of the two rising strobes.
- R2: A load writes byte offset `addr[OFF_W-1:0]` of the page `addr[ADDR_W-1:OFF_W]`. After programming, only the offsets that were loaded change in the array. If one offset is loaded twice, the later byte is kept.
- R3: While a page is open, a load whose page field differs from the first load's page is ignored. It leaves the array unchanged and does not restart the load window.
- R4: `busy` rises exactly `WINDOW_CYC` clocks after the clock edge that registered the start of the latest accepted load. A page has no length limit as long as each load starts inside the window.
- R5: `busy` stays high for exactly `PROG_CYC + 2**OFF_W` clocks. When it falls, the array holds the committed page.
- R6: A write cycle that starts while `busy` is high is ignored.
- R7: A read that starts while `busy` is high returns a status byte with these bits:
  - bit 7 is the inverse of bit 7 of the last accepted byte;
  - bits 5:0 equal that byte's bits 5:0;
  - bit 6 inverts on each successive such read.
- R8: `dout_en` is 1 exactly one clock after a clock in which `ce_n`=0 and `oe_n`=0, and 0 otherwise. When `busy` is low, a read returns the array byte at `addr` one clock after the read begins.
- R9: `dbg_data` returns the array byte at `dbg_addr` one clock later.
- R10: After reset:
  - `busy` and `dout_en` are 0;
  - no page is open;
  - the array reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low read strobe |
| we_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data (zero when not driving) |
| dout_en | output | 1 | Output drive enable for the data bus |
| busy | output | 1 | High during programming and commit |
| dbg_addr | input | ADDR_W | Debug array read address |
| dbg_data | output | DATA_W | Debug array read data |

## Verification
The bench times every check from the clock edge that registered the relevant stimulus. It records the cycle number of each accepted load start and then samples at a falling edge:
- for R4, `busy` is sampled at `WINDOW_CYC-1` clocks after that edge, where it must still be low, and at `WINDOW_CYC` clocks, where it must be high;
- for R5, it is sampled at `WINDOW_CYC+PROG_CYC+2**OFF_W` clocks, minus one and exactly, to catch the fall.

Read data, `dout_en` and the debug port are all sampled at the first falling edge after the edge that registered the read. This one-clock latency is set by the registered output stage. Array contents are checked over the full address range against an arithmetic model after each programming phase.

// File: rtl/epw_pkg.sv
package epw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_PROG   = 2'd2,
    ST_COMMIT = 2'd3
  } epw_state_t;
endpackage

// File: rtl/epw_strobe.sv
// Samples the three bus strobes on the system clock and derives load/read events.
module epw_strobe #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [OFF_W-1:0]  off_in,
  input  logic [DATA_W-1:0] din,
  output logic              ld_start,
  output logic              ld_end,
  output logic [OFF_W-1:0]  ld_off,
  output logic [DATA_W-1:0] ld_data,
  output logic              rd_act,
  output logic              rd_start
);
  logic wr_act, wr_q, rd_q;

  assign wr_act   = !ce_n && !we_n && oe_n;
  assign rd_act   = !ce_n && !oe_n;
  assign ld_start = wr_act && !wr_q;
  assign ld_end   = !wr_act && wr_q;
  assign rd_start = rd_act && !rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end

  // offset taken when the later strobe falls; data tracks the bus until the first rise
  always_ff @(posedge clk) begin
    if (ld_start) ld_off  <= off_in;
    if (wr_act)   ld_data <= din;
  end
endmodule

// File: rtl/epw_page_buf.sv
// One page of byte storage with a loaded flag per offset.
module epw_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int PAGE_N = 1 << OFF_W;

  logic [DATA_W-1:0] bytes_q [PAGE_N];
  logic [PAGE_N-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) bytes_q[wr_off] <= wr_data;
  end

  for (genvar g = 0; g < PAGE_N; g++) begin : g_valid
    always_ff @(posedge clk) begin
      if (rst || clr) valid_q[g] <= 1'b0;
      else if (wr_en && wr_off == OFF_W'(g)) valid_q[g] <= 1'b1;
    end
  end

  assign rd_data  = bytes_q[rd_off];
  assign rd_valid = valid_q[rd_off];
endmodule

// File: rtl/epw_seq.sv
// Page window timer, programming timer and commit walker.
module epw_seq
  import epw_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int OFF_W      = 6,
  parameter int WINDOW_CYC = 5000,
  parameter int PROG_CYC   = 100000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_start,
  input  logic                    ld_end,
  input  logic [ADDR_W-OFF_W-1:0] start_page,
  output logic                    accept_end,
  output logic [ADDR_W-OFF_W-1:0] page,
  output logic                    busy,
  output logic                    cmt_we,
  output logic [OFF_W-1:0]        cmt_idx,
  output logic                    buf_clr
);
  localparam int WCNT_W = $clog2(WINDOW_CYC + 1);
  localparam int PCNT_W = $clog2(PROG_CYC + 1);
  localparam logic [WCNT_W-1:0] W_LAST = WCNT_W'(WINDOW_CYC - 1);
  localparam logic [PCNT_W-1:0] P_LAST = PCNT_W'(PROG_CYC - 1);

  epw_state_t        st;
  logic              pend;
  logic [WCNT_W-1:0] wcnt;
  logic [PCNT_W-1:0] pcnt;
  logic [OFF_W-1:0]  idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      pend <= 1'b0;
      wcnt <= '0;
      pcnt <= '0;
      idx  <= '0;
      page <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (ld_start) begin
            st   <= ST_LOAD;
            page <= start_page;
            pend <= 1'b1;
            wcnt <= '0;
          end
        end
        ST_LOAD: begin
          if (ld_start && start_page == page) begin
            pend <= 1'b1;
            wcnt <= '0;
          end else begin
            if (ld_end) pend <= 1'b0;
            if (!pend && wcnt == W_LAST) begin
              st   <= ST_PROG;
              pcnt <= '0;
            end else if (wcnt != W_LAST) begin
              wcnt <= wcnt + 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (pcnt == P_LAST) begin
            st  <= ST_COMMIT;
            idx <= '0;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: begin
          idx <= idx + 1'b1;
          if (&idx) st <= ST_IDLE;
        end
      endcase
    end
  end

  assign accept_end = ld_end && pend && (st == ST_LOAD);
  assign busy       = (st == ST_PROG) || (st == ST_COMMIT);
  assign cmt_we     = (st == ST_COMMIT);
  assign cmt_idx    = idx;
  assign buf_clr    = (st == ST_COMMIT) && (&idx);
endmodule

// File: rtl/eeprom_page_engine.sv
module eeprom_page_engine #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int OFF_W      = 6,
  parameter int WINDOW_CYC = 5000,
  parameter int PROG_CYC   = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PG_W  = ADDR_W - OFF_W;

  logic              ld_start, ld_end, rd_act, rd_start, accept_end;
  logic [OFF_W-1:0]  ld_off, cmt_idx;
  logic [DATA_W-1:0] ld_data, buf_data, last_q, rd_q;
  logic [PG_W-1:0]   page;
  logic              cmt_we, buf_clr, buf_valid;
  logic              rd_en_q, poll_q, tog_q;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  epw_strobe #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_strobe (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .off_in(addr[OFF_W-1:0]), .din(din),
    .ld_start(ld_start), .ld_end(ld_end), .ld_off(ld_off), .ld_data(ld_data),
    .rd_act(rd_act), .rd_start(rd_start)
  );

  epw_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WINDOW_CYC(WINDOW_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst(rst), .ld_start(ld_start), .ld_end(ld_end),
    .start_page(addr[ADDR_W-1:OFF_W]), .accept_end(accept_end), .page(page),
    .busy(busy), .cmt_we(cmt_we), .cmt_idx(cmt_idx), .buf_clr(buf_clr)
  );

  epw_page_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst(rst), .wr_en(accept_end), .wr_off(ld_off), .wr_data(ld_data),
    .clr(buf_clr), .rd_off(cmt_idx), .rd_data(buf_data), .rd_valid(buf_valid)
  );

  // array: one write port for commit, registered read ports
  always_ff @(posedge clk) begin
    if (cmt_we && buf_valid) mem[{page, cmt_idx}] <= buf_data;
    rd_q     <= mem[addr];
    dbg_data <= mem[dbg_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q  <= '0;
      rd_en_q <= 1'b0;
      poll_q  <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      if (accept_end) last_q <= ld_data;
      rd_en_q <= rd_act;
      poll_q  <= busy;
      if (rd_start && busy) tog_q <= ~tog_q;
    end
  end

  assign dout_en = rd_en_q;
  assign dout = !rd_en_q ? '0 :
                poll_q   ? {~last_q[DATA_W-1], tog_q, last_q[DATA_W-3:0]} : rd_q;
endmodule

// File: rtl/epw_chk.sv
module epw_chk #(
  parameter int DATA_W   = 8,
  parameter int OFF_W    = 6,
  parameter int PROG_CYC = 100000
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              oe_n,
  input logic              busy,
  input logic              dout_en,
  input logic [DATA_W-1:0] dout
);
  localparam int BUSY_LEN = PROG_CYC + (1 << OFF_W);

  int   bcnt;
  logic en_q, busy_q, have_prev, prev_b6, poll_now;

  assign poll_now = dout_en && !en_q && busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt <= 0; en_q <= 1'b0; busy_q <= 1'b0; have_prev <= 1'b0; prev_b6 <= 1'b0;
    end else begin
      bcnt   <= busy ? bcnt + 1 : 0;
      en_q   <= dout_en;
      busy_q <= busy;
      if (poll_now) begin
        have_prev <= 1'b1;
        prev_b6   <= dout[6];
      end else if (!busy) begin
        have_prev <= 1'b0;
      end
    end
  end

  // R10
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !dout_en));
  // R8
  drive_on_chk: assert property (@(posedge clk) disable iff (rst) (!ce_n && !oe_n) |=> dout_en);
  // R8
  drive_off_chk: assert property (@(posedge clk) disable iff (rst) (ce_n || oe_n) |=> !dout_en);
  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (bcnt == BUSY_LEN));
  // R7
  poll_toggle_chk: assert property (@(posedge clk) disable iff (rst) (poll_now && have_prev) |-> (dout[6] != prev_b6));
endmodule

bind eeprom_page_engine epw_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W), .PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .busy(busy), .dout_en(dout_en), .dout(dout)
);

// File: tb/sim_eeprom_page_engine.sv
module sim_eeprom_page_engine;
  localparam int AW = 8, DW = 8, OW = 3, WIN = 16, PRG = 30;
  localparam int PAGE_N = 1 << OW;
  localparam int BLEN = PRG + PAGE_N;

  logic clk = 1'b0, rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0, dbg_addr = '0;
  logic [DW-1:0] din = '0, dout, dbg_data;
  logic dout_en, busy;

  int cyc = 0, errors = 0, checks = 0;
  logic [DW-1:0] model [1 << AW];
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eeprom_page_engine #(.ADDR_W(AW), .DATA_W(DW), .OFF_W(OW), .WINDOW_CYC(WIN), .PROG_CYC(PRG)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .busy(busy), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // write cycle controlled by both strobes together; returns the start edge number
  task automatic wr(input int a, input int d, output int e);
    @(negedge clk); addr = AW'(a); din = DW'(d); oe_n = 1; ce_n = 0; we_n = 0;
    @(negedge clk); e = cyc;
    @(negedge clk); ce_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input int a, output int d, output bit en);
    @(negedge clk); addr = AW'(a); ce_n = 0; oe_n = 0;
    @(negedge clk); d = dout; en = dout_en; ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic check_array(input string req);
    for (int i = 0; i < (1 << AW); i++) begin
      @(negedge clk); dbg_addr = AW'(i);
      @(negedge clk);
      chk(dbg_data == model[i], req, dbg_data, model[i]);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int e, e_last, d, prev6;
    bit en;
    int offs [8] = '{5, 0, 7, 2, 1, 6, 3, 4};
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(busy == 0, "R10 busy", busy, 0);
    chk(dout_en == 0, "R10 dout_en", dout_en, 0);
    check_array("R10 zero array");

    // Scenario A: full page 3, offsets out of order (R1, R2, R4)
    for (int k = 0; k < 8; k++) begin
      wr(24 + offs[k], 8'h80 ^ ((offs[k] * 37) & 8'hff), e);
      model[24 + offs[k]] = DW'(8'h80 ^ ((offs[k] * 37) & 8'hff));
    end
    e_last = e;
    wait_to(e_last + WIN - 1);
    chk(busy == 0, "R4 busy before window end", busy, 0);
    wait_to(e_last + WIN);
    chk(busy == 1, "R4 busy at window end", busy, 1);
    // R7 polling: last byte at offset 4 = 0x80^(148&ff)=0x14
    prev6 = -1;
    for (int k = 0; k < 3; k++) begin
      rd(27, d, en);
      chk(en == 1, "R7 poll drive", en, 1);
      chk(d[7] == 1'b1, "R7 inverted bit7", d[7], 1);
      chk(d[5:0] == 6'h14, "R7 low bits", d[5:0], 6'h14);
      if (prev6 >= 0) chk(d[6] != prev6[0], "R7 bit6 toggles", d[6], !prev6[0]);
      prev6 = int'(d[6]);
    end
    // R6 write during busy is ignored
    wr(25, 8'h55, e);
    wr(200, 8'h66, e);
    wait_to(e_last + WIN + BLEN - 1);
    chk(busy == 1, "R5 busy before end", busy, 1);
    wait_to(e_last + WIN + BLEN);
    chk(busy == 0, "R5 busy fall", busy, 0);
    check_array("R2 R5 R6 R9 page A");
    // R8 idle read of array
    rd(31, d, en);
    chk(en == 1 && d == model[31], "R8 idle read", d, model[31]);

    // Scenario B: repeated offset, foreign page, long page (R2, R3, R4)
    wr(42, 8'h11, e);
    for (int k = 0; k < 5; k++) begin
      wait_to(e + WIN - 4);
      chk(busy == 0, "R4 page stays open", busy, 0);
      wr(42, 8'h20 + k, e);
    end
    wait_to(e + WIN - 4);
    wr(46, 8'h3C, e);
    e_last = e;
    wr(17, 8'hEE, e);  // page 2, foreign
    wait_to(e_last + WIN - 1);
    chk(busy == 0, "R3 no restart before", busy, 0);
    wait_to(e_last + WIN);
    chk(busy == 1, "R3 window from accepted load", busy, 1);
    rd(46, d, en);
    chk(d[7] == 1'b1 && d[5:0] == 6'h3C, "R7 poll page B", d, 8'hBC);
    wait_to(e_last + WIN + BLEN);
    model[42] = 8'h24;
    model[46] = 8'h3C;
    chk(busy == 0, "R5 page B done", busy, 0);
    check_array("R2 R3 page B");

    // Scenario C: chip-select-controlled write (R1)
    @(negedge clk); addr = 8'h61; din = 8'hAA; oe_n = 1; we_n = 0;
    @(negedge clk); addr = 8'h72; din = 8'h5A; ce_n = 0;
    @(negedge clk); e_last = cyc; addr = 8'h61;
    chk(dout_en == 0, "R8 no drive during write", dout_en, 0);
    @(negedge clk); ce_n = 1;
    @(negedge clk); din = 8'hC3;
    @(negedge clk); we_n = 1;
    model[8'h72] = 8'h5A;
    wait_to(e_last + WIN + BLEN);
    chk(busy == 0, "R1 commit done", busy, 0);
    check_array("R1 strobe capture");
    rd(8'h72, d, en);
    chk(en == 1 && d == 8'h5A, "R1 R8 read back", d, 8'h5A);
    @(negedge clk); ce_n = 1; oe_n = 0;
    @(negedge clk);
    chk(dout_en == 0, "R8 no drive when deselected", dout_en, 0);
    oe_n = 1;
    @(negedge clk);
    finish_run();
  end
endmodule